// File: doc/BRIEF.md
# Mixed-Sign Saturating Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath. Each cycle it may take two 16-bit operands. Each operand has its own signed/unsigned select, so signed, unsigned and mixed-sign products all come from one 17x17 signed multiplier. The product can be taken as an integer or as a fractional value. In fractional mode it is doubled. It is then sign-extended to 40 bits. The operation then either loads it into one of two 40-bit accumulators, or adds it to that accumulator, or subtracts it from that accumulator.

The 40-bit sum can wrap or can be clamped to the 40-bit limits. Three registered flags describe the most recent operation: a 40-bit overflow, an excursion of the written value beyond the 32-bit signed range, and whether a clamp took place. A separate read select shows either accumulator at the output at any time. The fractional corner case (-1.0)x(-1.0) yields the exact positive value +1.0 in the accumulator.

Top module: `mac_sat_unit`

## Requirements
- R1: Each 16-bit operand is widened to 17 bits by its own select. When the select is 1 the operand is sign-extended, and when it is 0 the operand is zero-extended. The product is the signed product of the two widened values.
- R2: When `frac_i` is 0 the product is used unshifted. When `frac_i` is 1 the product is shifted left by one bit. In both modes it is then sign-extended to 40 bits.
- R3: A cycle with `valid_i` high writes only the accumulator chosen by `acc_sel_i`, at that clock edge. The other accumulator keeps its value, and with `valid_i` low neither accumulator changes.
- R4: `op_i` encoding: 2'b00 loads the product, 2'b01 adds the product to the accumulator, 2'b10 subtracts the product from the accumulator, and 2'b11 loads the negated product.
- R5: Fractional mode with both operands signed and equal to 16'h8000 loads exactly 40'h00_8000_0000.
- R6: If the true sum leaves the 40-bit signed range and `sat_en_i` is 1, the result is clamped to 40'h7F_FFFF_FFFF or 40'h80_0000_0000 according to the sign of the true sum, and `sat_o` is set. If `sat_en_i` is 0, the result wraps modulo 2^40 and `sat_o` is 0.
- R7: `ovf_hi_o` is set when the true sum leaves the 40-bit signed range, whether or not saturation is enabled. `ovf_lo_o` is set when the value written has bits 39 down to 31 not all equal.
- R8: Reset clears both accumulators and all three flags. The flags change only on cycles with `valid_i` high and hold otherwise.
- R9: `acc_o` shows the accumulator chosen by `rd_sel_i` and follows `rd_sel_i` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Perform an operation this cycle |
| op_i | input | 2 | Operation: load, add, subtract, load negated |
| acc_sel_i | input | 1 | Destination accumulator |
| rd_sel_i | input | 1 | Accumulator shown on acc_o |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_signed_i | input | 1 | First operand is signed |
| b_signed_i | input | 1 | Second operand is signed |
| frac_i | input | 1 | Fractional mode (product doubled) |
| sat_en_i | input | 1 | Clamp on 40-bit overflow |
| acc_o | output | 40 | Selected accumulator value |
| ovf_hi_o | output | 1 | Last operation overflowed 40 bits |
| ovf_lo_o | output | 1 | Last written value exceeds 32-bit signed range |
| sat_o | output | 1 | Last operation was clamped |

## Verification
The clamp and the two overflow flags can fall in the same cycle. A saturating add past the 40-bit limit must raise `ovf_hi_o`, `ovf_lo_o` and `sat_o` together and write the limit value. The bench provokes this with long chains of fractional unsigned-by-unsigned products added and then subtracted with saturation on, and repeats the chain with saturation off to see the wrap. A scoreboard model computed with 64-bit integers supplies the value and all three flags for every cycle, and the bench compares them against the outputs.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MAC_LOAD  = 2'b00,
    MAC_ADD   = 2'b01,
    MAC_SUB   = 2'b10,
    MAC_LOADN = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0]   d_i,
  input  logic              is_signed_i,
  output logic signed [IN_W:0] q_o
);
  assign q_o = {is_signed_i & d_i[IN_W-1], d_i};
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic signed [IN_W:0]    a_i,
  input  logic signed [IN_W:0]    b_i,
  input  logic                    frac_i,
  output logic signed [ACC_W-1:0] prod_o
);
  localparam int PW = 2 * (IN_W + 1);

  logic signed [PW-1:0]    raw;
  logic signed [ACC_W-1:0] wide;

  assign raw  = a_i * b_i;
  assign wide = {{(ACC_W-PW){raw[PW-1]}}, raw};
  // fractional: drop the duplicate sign bit
  assign prod_o = frac_i ? {wide[ACC_W-2:0], 1'b0} : wide;

  always_comb begin
    if (!a_i[IN_W] && !b_i[IN_W]) begin
      assert_nonneg_prod_R1: assert (!raw[PW-1]);
    end
  end
endmodule

// File: rtl/mac_acc_adder.sv
module mac_acc_adder
  import mac_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int LO_W  = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] prod_i,
  input  mac_op_e          op_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] res_o,
  output logic             ovf_hi_o,
  output logic             ovf_lo_o,
  output logic             sat_o
);
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};
  localparam int HI_N = ACC_W - LO_W + 1;

  logic [ACC_W:0]  base, term, sum;
  logic            is_load, is_neg;
  logic [HI_N-1:0] top_bits;

  always_comb begin
    is_load = (op_i == MAC_LOAD) || (op_i == MAC_LOADN);
    is_neg  = (op_i == MAC_SUB)  || (op_i == MAC_LOADN);
    base    = is_load ? '0 : {acc_i[ACC_W-1], acc_i};
    term    = {prod_i[ACC_W-1], prod_i};
    if (is_neg) term = -term;
    sum      = base + term;
    ovf_hi_o = sum[ACC_W] ^ sum[ACC_W-1];
    sat_o    = ovf_hi_o & sat_en_i;
    if (sat_o) res_o = sum[ACC_W] ? NEG_MAX : POS_MAX;
    else       res_o = sum[ACC_W-1:0];
    top_bits = res_o[ACC_W-1:LO_W-1];
    ovf_lo_o = !((&top_bits) || !(|top_bits));
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int ACC_W   = 40,
  parameter int LO_W    = 32,
  parameter int NUM_ACC = 2,
  localparam int SEL_W  = $clog2(NUM_ACC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [SEL_W-1:0] acc_sel_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  input  logic             a_signed_i,
  input  logic             b_signed_i,
  input  logic             frac_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_hi_o,
  output logic             ovf_lo_o,
  output logic             sat_o
);
  localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [IN_W:0]    a_ext, b_ext;
  logic signed [ACC_W-1:0] prod;
  logic [ACC_W-1:0]        acc_q [NUM_ACC];
  logic [ACC_W-1:0]        acc_cur, res;
  logic                    hi_d, lo_d, sat_d;

  mac_operand_ext #(.IN_W(IN_W)) i_ext_a (
    .d_i(a_i), .is_signed_i(a_signed_i), .q_o(a_ext)
  );
  mac_operand_ext #(.IN_W(IN_W)) i_ext_b (
    .d_i(b_i), .is_signed_i(b_signed_i), .q_o(b_ext)
  );

  mac_multiplier #(.IN_W(IN_W), .ACC_W(ACC_W)) i_mult (
    .a_i(a_ext), .b_i(b_ext), .frac_i(frac_i), .prod_o(prod)
  );

  assign acc_cur = acc_q[acc_sel_i];

  mac_acc_adder #(.ACC_W(ACC_W), .LO_W(LO_W)) i_adder (
    .acc_i(acc_cur), .prod_i(prod), .op_i(mac_op_e'(op_i)),
    .sat_en_i(sat_en_i), .res_o(res), .ovf_hi_o(hi_d),
    .ovf_lo_o(lo_d), .sat_o(sat_d)
  );

  for (genvar j = 0; j < NUM_ACC; j++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     acc_q[j] <= '0;
      else if (valid_i && acc_sel_i == SEL_W'(j))      acc_q[j] <= res;
    end

    assert_keep_unselected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && acc_sel_i != SEL_W'(j)) |=> $stable(acc_q[j]));

    assert_sat_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && acc_sel_i == SEL_W'(j)) |=>
        (!sat_o || acc_q[j] == POS_MAX || acc_q[j] == NEG_MAX));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_hi_o <= 1'b0;
      ovf_lo_o <= 1'b0;
      sat_o    <= 1'b0;
    end else if (valid_i) begin
      ovf_hi_o <= hi_d;
      ovf_lo_o <= lo_d;
      sat_o    <= sat_d;
    end
  end

  assign acc_o = acc_q[rd_sel_i];

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({ovf_hi_o, ovf_lo_o, sat_o}));

  assert_sat_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sat_en_i) |=> !sat_o);

  assert_sat_implies_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> ovf_hi_o);
endmodule

// File: tb/test_mac_sat_unit.sv
module test_mac_sat_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        acc_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        a_s = 1'b0, b_s = 1'b0, frac = 1'b0, sat_en = 1'b0;
  logic [39:0] acc_o;
  logic        ovf_hi, ovf_lo, sat;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic [39:0] acc;
    logic hi, lo, st;
    string tag;
  } item_t;
  item_t sb[$];

  longint model_acc [2];
  logic   m_hi = 0, m_lo = 0, m_sat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sat_unit i_mac_sat_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .acc_sel_i(acc_sel), .rd_sel_i(rd_sel), .a_i(a), .b_i(b),
    .a_signed_i(a_s), .b_signed_i(b_s), .frac_i(frac), .sat_en_i(sat_en),
    .acc_o(acc_o), .ovf_hi_o(ovf_hi), .ovf_lo_o(ovf_lo), .sat_o(sat)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes its expected result
  task automatic issue(input bit v, input logic [1:0] o, input bit sel,
                       input logic [15:0] av, input logic [15:0] bv,
                       input bit as_, input bit bs_, input bit fr, input bit se,
                       input string tag);
    longint ea, eb, p, base, sum, res;
    logic [39:0] w;
    item_t it;
    @(negedge clk);
    valid = v; op = o; acc_sel = sel; rd_sel = sel;
    a = av; b = bv; a_s = as_; b_s = bs_; frac = fr; sat_en = se;
    if (v) begin
      ea = as_ ? longint'($signed(av)) : longint'({48'd0, av});
      eb = bs_ ? longint'($signed(bv)) : longint'({48'd0, bv});
      p = ea * eb;
      if (fr) p = p * 2;
      if (o == 2'b10 || o == 2'b11) p = -p;
      base = (o == 2'b00 || o == 2'b11) ? 64'sd0 : model_acc[sel];
      sum = base + p;
      m_hi = (sum > 64'sh7F_FFFF_FFFF) || (sum < -64'sh80_0000_0000);
      m_sat = m_hi && se;
      if (m_sat) res = (sum < 0) ? -64'sh80_0000_0000 : 64'sh7F_FFFF_FFFF;
      else begin
        w = sum[39:0];
        res = longint'($signed(w));
      end
      m_lo = (res > 64'sh7FFF_FFFF) || (res < -64'sh8000_0000);
      model_acc[sel] = res;
    end
    it.acc = model_acc[sel][39:0];
    it.hi = m_hi; it.lo = m_lo; it.st = m_sat; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares one scoreboard item per cycle, a quarter period after the edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, acc_o, it.acc);
        check({it.tag, " flags"}, {37'd0, ovf_hi, ovf_lo, sat}, {37'd0, it.hi, it.lo, it.st});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_acc[0] = 0; model_acc[1] = 0;
    #(CLK_PERIOD * 3);
    // R8 reset state
    check("R8 reset acc0", acc_o, 40'd0);
    rd_sel = 1'b1;
    #1 check("R8 reset acc1", acc_o, 40'd0);
    check("R8 reset flags", {37'd0, ovf_hi, ovf_lo, sat}, 40'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 sign combinations on 0xFFFF x 0xFFFF, integer load
    issue(1, 2'b00, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, "R1 uu");
    issue(1, 2'b00, 0, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, "R1 su");
    issue(1, 2'b00, 0, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, "R1 us");
    issue(1, 2'b00, 0, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, "R1 ss");
    issue(1, 2'b00, 0, 16'h8000, 16'h7FFF, 1, 1, 0, 0, "R1 neg");
    // R2 fractional doubling
    issue(1, 2'b00, 1, 16'h4000, 16'h4000, 1, 1, 1, 0, "R2 frac");
    issue(1, 2'b00, 1, 16'hC000, 16'h4000, 1, 1, 1, 0, "R2 frac neg");
    // R5 (-1.0)x(-1.0)
    issue(1, 2'b00, 0, 16'h8000, 16'h8000, 1, 1, 1, 1, "R5 minus one squared");
    check("R5 exact", model_acc[0][39:0], 40'h00_8000_0000);
    // R4 op encodings on acc1, R3 acc0 held
    issue(1, 2'b01, 1, 16'd100, 16'd7, 1, 1, 0, 0, "R4 add");
    issue(1, 2'b10, 1, 16'd50, 16'd3, 1, 1, 0, 0, "R4 sub");
    issue(1, 2'b11, 1, 16'd9, 16'd9, 1, 1, 0, 0, "R4 load neg");
    issue(0, 2'b01, 0, 16'h1234, 16'h5678, 1, 1, 0, 0, "R3 idle acc0 held");
    issue(0, 2'b01, 1, 16'h1234, 16'h5678, 1, 1, 0, 0, "R8 idle flags held");
    // R9 combinational read select
    @(negedge clk); rd_sel = 1'b0;
    #1 check("R9 read acc0", acc_o, model_acc[0][39:0]);
    rd_sel = 1'b1;
    #1 check("R9 read acc1", acc_o, model_acc[1][39:0]);

    // R6/R7 positive saturation chain
    issue(1, 2'b00, 0, 16'hFFFF, 16'hFFFF, 0, 0, 1, 1, "R6 chain start");
    for (int i = 0; i < 70; i++)
      issue(1, 2'b01, 0, 16'hFFFF, 16'hFFFF, 0, 0, 1, 1, "R6 R7 sat add");
    for (int i = 0; i < 140; i++)
      issue(1, 2'b10, 0, 16'hFFFF, 16'hFFFF, 0, 0, 1, 1, "R6 R7 sat sub");
    // wrap without saturation
    issue(1, 2'b00, 1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, "R6 wrap start");
    for (int i = 0; i < 70; i++)
      issue(1, 2'b01, 1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, "R6 R7 wrap add");

    // mixed random traffic
    for (int i = 0; i < 400; i++)
      issue($urandom_range(0, 4) != 0, 2'($urandom), 1'($urandom),
            16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), "R1 R2 R3 R4 R6 R7 R8 random");

    @(negedge clk); valid = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule